// File: doc/BRIEF.md
# HIPPI Source Connection Controller

This block is the source-side connection manager of a HIPPI channel. It takes a connect request and a three-bit mode select from the host. From the channel it takes the destination's CONNECT and READY lines and the interconnect-present signal. It drives REQUEST onto the channel and runs the whole life of a connection: the request, the destination's answer, the teardown started by either end, and every sequencing fault in between.

The destination answers a request by holding CONNECT high. The controller counts how many cycles in a row CONNECT stays high, and that count decides whether the answer is an acceptance or a rejection. The host sees the result on three outputs: connect out, accept/reject and destination available. A sequence-error output reports faults, and an origin flag next to it tells a fault caused by the host apart from one caused by the destination.

The host leaves the connection machinery parked by selecting reset or wait mode. Loss of the interconnect signal parks the controller in a non-operational state that only the host can clear.

Top module: `hsrc_conn_ctrl`

## Requirements
- R1: The mode select encodes operational as 3'b001, reset as 3'b000 and wait as 3'b010. Every other code acts like reset. While reset or wait is selected and the interconnect signal is present, the controller is parked on the cycle after the clock edge: REQUEST low, no sequence error, destination available high. One cycle after operational mode returns, the controller is idle.
- R2: When the controller is idle in operational mode and the host raises its connect request, REQUEST goes high on the next cycle. It stays high while the request is pending.
- R3: If CONNECT is sampled high on 17 consecutive clock edges while a request is pending, the connection is accepted. Connect out and accept/reject are then both 1, REQUEST stays high, and from then on connect out equals CONNECT in the same cycle.
- R4: If CONNECT is high for 3 to 16 consecutive edges during a request and then goes low, the request is rejected. REQUEST drops, connect out is 1 and accept/reject is 0, and this lasts until the host drops its request. A CONNECT pulse of only 1 or 2 cycles is ignored and the request stays pending.
- R5: If the host drops its request before acceptance, REQUEST drops and the controller aborts. It returns to idle once CONNECT is low. If the host raises its request again while the abort is still open, this is a source error.
- R6: If the host drops its request while connected, REQUEST drops and the controller waits for CONNECT to go low, then returns to idle. During the wait, connect out follows CONNECT and accept/reject stays 1. A new request during the wait is a source error.
- R7: If the destination drops CONNECT while connected and the host still requests, this is an illegal termination: connect out goes to 0 while accept/reject stays 1. The controller returns to idle when the host drops its request. CONNECT or READY high during the illegal termination is a destination error.
- R8: READY high while a request is pending and not yet accepted is a destination error. A destination error drives sequence error to 1 and the origin flag to 0.
- R9: A source error drives sequence error to 1 and the origin flag to 1. Both error kinds end, back to idle, on the edge where the host request and CONNECT are both low.
- R10: If the interconnect signal drops while in operational mode, destination available goes to 0 and REQUEST, connect out and accept/reject go to 0. This holds in operational mode whatever the other inputs do, until reset or wait is selected.
- R11: While reset or wait is selected and the interconnect signal is absent, destination available is 0. This persists even after operational mode is selected again. It clears only when the interconnect signal returns while reset or wait is selected.
- R12: After the reset input is released, every output is 0 except destination available, which is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_conn_req_i | input | 1 | Host connect request |
| mode_sel_i | input | 3 | Host mode: 001 operational, 000 reset, 010 wait |
| dst_connect_i | input | 1 | Destination CONNECT line |
| dst_ready_i | input | 1 | Destination READY line |
| dst_present_i | input | 1 | Destination-to-source interconnect present |
| chan_request_o | output | 1 | REQUEST driven onto the channel |
| dst_avail_o | output | 1 | Destination available |
| conn_out_o | output | 1 | Connect out to host |
| acc_rej_o | output | 1 | 1 accept, 0 reject |
| seq_err_o | output | 1 | Sequence error |
| err_src_o | output | 1 | Error origin: 1 source, 0 destination |

## Verification
The assertions check several rules on every cycle:
- the origin flag is only raised together with a sequence error;
- a lost or absent destination silences REQUEST and connect out, and stays lost in operational mode;
- connect out tracks CONNECT once a connection is accepted;
- a rejection holds while the host keeps requesting;
- READY during a pending request produces a destination error;
- REQUEST only rises after a host request;
- reset or wait mode parks the controller.

Only the bench's scenarios can show that the CONNECT run-length boundaries are placed correctly: 2 against 3 cycles, and 16 against 17. The same holds for the abort, terminate and illegal-termination sequences, for the return of the interconnect signal clearing the no-destination state, and for the whole transition table under random traffic.

// File: rtl/hsrc_pkg.sv
package hsrc_pkg;

  typedef enum logic [3:0] {
    ST_HOLD,
    ST_IDLE,
    ST_REQ,
    ST_RESP,
    ST_REJECT,
    ST_LINKED,
    ST_ILLTERM,
    ST_TERMCON,
    ST_ABORT,
    ST_DSTERR,
    ST_SRCERR,
    ST_LOST,
    ST_NODEST
  } conn_state_e;

  localparam logic [2:0] MODE_RESET = 3'b000;
  localparam logic [2:0] MODE_RUN   = 3'b001;
  localparam logic [2:0] MODE_WAIT  = 3'b010;

endpackage

// File: rtl/hsrc_rst_sync.sv
module hsrc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/hsrc_resp_counter.sv
module hsrc_resp_counter #(
  parameter int ACCEPT_CYCLES = 17,
  localparam int CW = $clog2(ACCEPT_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          connect_i,
  output logic [CW-1:0] count_o
);

  localparam logic [CW-1:0] CMAX = CW'(ACCEPT_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  // Counts consecutive CONNECT cycles, saturating at the accept threshold.
  always_comb begin
    cnt_en = connect_i || (cnt_q != '0);
    if (!connect_i) begin
      cnt_d = '0;
    end else if (cnt_q == CMAX) begin
      cnt_d = cnt_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign count_o = cnt_q;

endmodule

// File: rtl/hsrc_conn_fsm.sv
module hsrc_conn_fsm
  import hsrc_pkg::*;
#(
  parameter int ACCEPT_CYCLES = 17,
  parameter int REJECT_MIN    = 3,
  localparam int CW = $clog2(ACCEPT_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          conn_req_i,
  input  logic [2:0]    mode_i,
  input  logic          connect_i,
  input  logic          ready_i,
  input  logic          present_i,
  input  logic [CW-1:0] count_i,
  output conn_state_e   state_o
);

  localparam logic [CW-1:0] ACC_LAST = CW'(ACCEPT_CYCLES - 1);
  localparam logic [CW-1:0] REJ_MIN  = CW'(REJECT_MIN);

  conn_state_e st_q, st_d;
  logic        hold_mode;

  always_comb begin
    hold_mode = (mode_i != MODE_RUN);
    st_d      = st_q;
    if (hold_mode) begin
      st_d = present_i ? ST_HOLD : ST_NODEST;
    end else if (st_q == ST_NODEST || st_q == ST_LOST) begin
      st_d = st_q;
    end else if (!present_i) begin
      st_d = ST_LOST;
    end else begin
      unique case (st_q)
        ST_HOLD: st_d = ST_IDLE;
        ST_IDLE: if (conn_req_i) st_d = ST_REQ;
        ST_REQ: begin
          if (!conn_req_i)    st_d = ST_ABORT;
          else if (ready_i)   st_d = ST_DSTERR;
          else if (connect_i) st_d = ST_RESP;
        end
        ST_RESP: begin
          if (!conn_req_i)             st_d = ST_ABORT;
          else if (ready_i)            st_d = ST_DSTERR;
          else if (connect_i)          st_d = (count_i >= ACC_LAST) ? ST_LINKED : ST_RESP;
          else if (count_i >= REJ_MIN) st_d = ST_REJECT;
          else                         st_d = ST_REQ;
        end
        ST_REJECT: if (!conn_req_i) st_d = ST_IDLE;
        ST_LINKED: begin
          if (!conn_req_i)     st_d = ST_TERMCON;
          else if (!connect_i) st_d = ST_ILLTERM;
        end
        ST_ILLTERM: begin
          if (connect_i || ready_i) st_d = ST_DSTERR;
          else if (!conn_req_i)     st_d = ST_IDLE;
        end
        ST_TERMCON, ST_ABORT: begin
          if (conn_req_i)      st_d = ST_SRCERR;
          else if (!connect_i) st_d = ST_IDLE;
        end
        ST_DSTERR, ST_SRCERR: if (!conn_req_i && !connect_i) st_d = ST_IDLE;
        default: st_d = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_HOLD;
    end else begin
      st_q <= st_d;
    end
  end

  assign state_o = st_q;

endmodule

// File: rtl/hsrc_out_decode.sv
module hsrc_out_decode
  import hsrc_pkg::*;
(
  input  conn_state_e state_i,
  input  logic        connect_i,
  output logic        request_o,
  output logic        avail_o,
  output logic        conn_out_o,
  output logic        acc_rej_o,
  output logic        seq_err_o,
  output logic        err_src_o
);

  always_comb begin
    request_o  = 1'b0;
    avail_o    = 1'b1;
    conn_out_o = 1'b0;
    acc_rej_o  = 1'b0;
    seq_err_o  = 1'b0;
    err_src_o  = 1'b0;
    unique case (state_i)
      ST_REQ, ST_RESP: request_o = 1'b1;
      ST_LINKED: begin
        request_o  = 1'b1;
        conn_out_o = connect_i;
        acc_rej_o  = 1'b1;
      end
      ST_ILLTERM, ST_TERMCON: begin
        conn_out_o = connect_i;
        acc_rej_o  = 1'b1;
      end
      ST_REJECT: conn_out_o = 1'b1;
      ST_DSTERR: seq_err_o = 1'b1;
      ST_SRCERR: begin
        seq_err_o = 1'b1;
        err_src_o = 1'b1;
      end
      ST_LOST, ST_NODEST: avail_o = 1'b0;
      default: ;
    endcase
  end

endmodule

// File: rtl/hsrc_conn_ctrl.sv
module hsrc_conn_ctrl
  import hsrc_pkg::*;
#(
  parameter int ACCEPT_CYCLES = 17,
  parameter int REJECT_MIN    = 3,
  parameter int SYNC_STAGES   = 2,
  localparam int CW = $clog2(ACCEPT_CYCLES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_conn_req_i,
  input  logic [2:0] mode_sel_i,
  input  logic       dst_connect_i,
  input  logic       dst_ready_i,
  input  logic       dst_present_i,
  output logic       chan_request_o,
  output logic       dst_avail_o,
  output logic       conn_out_o,
  output logic       acc_rej_o,
  output logic       seq_err_o,
  output logic       err_src_o
);

  logic          rst_int_n;
  logic [CW-1:0] run_cnt;
  conn_state_e   state;

  hsrc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  hsrc_resp_counter #(.ACCEPT_CYCLES(ACCEPT_CYCLES)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .connect_i (dst_connect_i),
    .count_o   (run_cnt)
  );

  hsrc_conn_fsm #(
    .ACCEPT_CYCLES (ACCEPT_CYCLES),
    .REJECT_MIN    (REJECT_MIN)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .conn_req_i (host_conn_req_i),
    .mode_i     (mode_sel_i),
    .connect_i  (dst_connect_i),
    .ready_i    (dst_ready_i),
    .present_i  (dst_present_i),
    .count_i    (run_cnt),
    .state_o    (state)
  );

  hsrc_out_decode u_dec (
    .state_i    (state),
    .connect_i  (dst_connect_i),
    .request_o  (chan_request_o),
    .avail_o    (dst_avail_o),
    .conn_out_o (conn_out_o),
    .acc_rej_o  (acc_rej_o),
    .seq_err_o  (seq_err_o),
    .err_src_o  (err_src_o)
  );

endmodule

// File: rtl/hsrc_conn_ctrl_chk.sv
module hsrc_conn_ctrl_chk
  import hsrc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       host_conn_req_i,
  input logic [2:0] mode_sel_i,
  input logic       dst_connect_i,
  input logic       dst_ready_i,
  input logic       dst_present_i,
  input logic       chan_request_o,
  input logic       dst_avail_o,
  input logic       conn_out_o,
  input logic       acc_rej_o,
  input logic       seq_err_o,
  input logic       err_src_o
);

  logic run_ok;
  assign run_ok = (mode_sel_i == MODE_RUN) && dst_present_i;

  p_hold_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel_i != MODE_RUN && dst_present_i) |=> (!chan_request_o && !seq_err_o && dst_avail_o));

  p_req_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chan_request_o) |-> $past(host_conn_req_i));

  p_follow_connect_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rej_o |-> (conn_out_o == dst_connect_i));

  p_reject_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (conn_out_o && !acc_rej_o && host_conn_req_i && run_ok) |=> (conn_out_o && !acc_rej_o));

  p_ready_derr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_request_o && !acc_rej_o && dst_ready_i && host_conn_req_i && run_ok)
      |=> (seq_err_o && !err_src_o));

  p_origin_needs_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_src_o |-> seq_err_o);

  p_lost_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !dst_avail_o |-> (!chan_request_o && !conn_out_o && !acc_rej_o));

  p_lost_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!dst_avail_o && mode_sel_i == MODE_RUN) |=> !dst_avail_o);

endmodule

bind hsrc_conn_ctrl hsrc_conn_ctrl_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .host_conn_req_i (host_conn_req_i),
  .mode_sel_i      (mode_sel_i),
  .dst_connect_i   (dst_connect_i),
  .dst_ready_i     (dst_ready_i),
  .dst_present_i   (dst_present_i),
  .chan_request_o  (chan_request_o),
  .dst_avail_o     (dst_avail_o),
  .conn_out_o      (conn_out_o),
  .acc_rej_o       (acc_rej_o),
  .seq_err_o       (seq_err_o),
  .err_src_o       (err_src_o)
);

// File: tb/tb_hsrc_conn_ctrl.sv
`timescale 1ns/1ps
module tb_hsrc_conn_ctrl;

  localparam int ACC = 17;
  localparam int REJ = 3;
  localparam logic [2:0] M_RST = 3'b000, M_RUN = 3'b001, M_WAIT = 3'b010;

  localparam int S_HOLD = 0, S_IDLE = 1, S_REQ = 2, S_RESP = 3, S_REJECT = 4,
                 S_LINKED = 5, S_ILL = 6, S_TERM = 7, S_ABORT = 8, S_DERR = 9,
                 S_SERR = 10, S_LOST = 11, S_NODEST = 12;

  logic clk = 1'b0;
  logic rst_n;
  logic req, con, rdy, pres;
  logic [2:0] mode;
  logic o_req, o_av, o_co, o_ar, o_se, o_es;

  int total = 0;
  int fails = 0;
  int ms = S_HOLD;
  int mc = 0;

  always #2.5 clk = ~clk;

  hsrc_conn_ctrl dut (
    .clk(clk), .rst_n(rst_n), .host_conn_req_i(req), .mode_sel_i(mode),
    .dst_connect_i(con), .dst_ready_i(rdy), .dst_present_i(pres),
    .chan_request_o(o_req), .dst_avail_o(o_av), .conn_out_o(o_co),
    .acc_rej_o(o_ar), .seq_err_o(o_se), .err_src_o(o_es)
  );

  // Reference model built from the requirements.
  function automatic int nxt(int s, int c);
    if (mode != M_RUN) return pres ? S_HOLD : S_NODEST;
    if (s == S_NODEST || s == S_LOST) return s;
    if (!pres) return S_LOST;
    case (s)
      S_HOLD: return S_IDLE;
      S_IDLE: return req ? S_REQ : S_IDLE;
      S_REQ: begin
        if (!req) return S_ABORT;
        if (rdy) return S_DERR;
        return con ? S_RESP : S_REQ;
      end
      S_RESP: begin
        if (!req) return S_ABORT;
        if (rdy) return S_DERR;
        if (con) return (c >= ACC - 1) ? S_LINKED : S_RESP;
        return (c >= REJ) ? S_REJECT : S_REQ;
      end
      S_REJECT: return req ? S_REJECT : S_IDLE;
      S_LINKED: begin
        if (!req) return S_TERM;
        return con ? S_LINKED : S_ILL;
      end
      S_ILL: begin
        if (con || rdy) return S_DERR;
        return req ? S_ILL : S_IDLE;
      end
      S_TERM, S_ABORT: begin
        if (req) return S_SERR;
        return con ? s : S_IDLE;
      end
      default: return (!req && !con) ? S_IDLE : s;
    endcase
  endfunction

  // {request, avail, conn_out, acc_rej, seq_err, err_src}
  function automatic logic [5:0] exp_out(int s);
    case (s)
      S_REQ, S_RESP: return 6'b110000;
      S_LINKED:      return {3'b11, con, 3'b100};
      S_ILL, S_TERM: return {3'b01, con, 3'b100};
      S_REJECT:      return 6'b011000;
      S_DERR:        return 6'b010010;
      S_SERR:        return 6'b010011;
      S_LOST, S_NODEST: return 6'b000000;
      default:       return 6'b010000;
    endcase
  endfunction

  function automatic string tag_of(int s);
    case (s)
      S_HOLD: return "R1";
      S_IDLE, S_REQ: return "R2";
      S_RESP, S_LINKED: return "R3";
      S_REJECT: return "R4";
      S_ABORT: return "R5";
      S_TERM: return "R6";
      S_ILL: return "R7";
      S_DERR: return "R8";
      S_SERR: return "R9";
      S_LOST: return "R10";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [5:0] act();
    return {o_req, o_av, o_co, o_ar, o_se, o_es};
  endfunction

  task automatic check(logic [5:0] exp, string tag);
    total++;
    if (act() !== exp) begin
      fails++;
      $display("FAIL %s: outputs %b expected %b at %0t", tag, act(), exp, $time);
    end
  endtask

  // One clock: advance model with current inputs, sample 1 ns after the edge.
  task automatic tick();
    int ns;
    ns = nxt(ms, mc);
    mc = con ? ((mc < ACC) ? mc + 1 : mc) : 0;
    ms = ns;
    @(posedge clk);
    #1;
    check(exp_out(ms), tag_of(ms));
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic set(logic r, logic [2:0] m, logic c, logic y, logic p);
    req = r; mode = m; con = c; rdy = y; pres = p;
  endtask

  initial begin
    #(150000 * 5);
    fails++;
    total++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int len;
    rst_n = 1'b0;
    set(0, M_RST, 0, 0, 1);
    #11 rst_n = 1'b1;
    run(3);
    check(6'b010000, "R12 reset state");

    // R1 / R2
    set(0, M_RUN, 0, 0, 1); run(2);
    set(1, M_RUN, 0, 0, 1); run(2);
    check(6'b110000, "R2 request raised");
    // R3 accept after 17 CONNECT cycles
    con = 1; run(16);
    check(6'b110000, "R3 16 cycles not yet accepted");
    run(1);
    check(6'b111100, "R3 accepted");
    // R7 illegal termination
    con = 0; run(1);
    check(6'b010100, "R7 illegal termination");
    req = 0; run(1);
    check(6'b010000, "R7 back to idle");
    // R4 reject with 5-cycle answer
    req = 1; run(2); con = 1; run(5); con = 0; run(1);
    check(6'b011000, "R4 rejected");
    run(3);
    check(6'b011000, "R4 reject held");
    req = 0; run(1);
    // R4 boundary: 2-cycle pulse ignored, 3-cycle pulse rejects
    req = 1; run(2); con = 1; run(2); con = 0; run(2);
    check(6'b110000, "R4 two-cycle pulse ignored");
    con = 1; run(3); con = 0; run(1);
    check(6'b011000, "R4 three-cycle reject");
    req = 0; run(1);
    // R8 READY during request
    req = 1; run(2); rdy = 1; run(1);
    check(6'b010010, "R8 destination error");
    rdy = 0; req = 0; run(1);
    // R5 abort, then R9 source error
    req = 1; run(2); con = 1; run(1); req = 0; run(1);
    check(6'b010000, "R5 abort drops request");
    req = 1; run(1);
    check(6'b010011, "R9 source error");
    req = 0; con = 0; run(1);
    // R6 terminate connection
    req = 1; run(1); con = 1; run(18); req = 0; run(1);
    check(6'b011100, "R6 waiting for CONNECT drop");
    con = 0; run(1);
    check(6'b010000, "R6 idle after drop");
    // R10 lost destination
    req = 1; run(1); pres = 0; run(1);
    check(6'b000000, "R10 lost");
    pres = 1; run(2);
    check(6'b000000, "R10 lost sticky");
    mode = M_WAIT; run(1);
    check(6'b010000, "R1 wait mode parks");
    // R11 no destination
    pres = 0; run(1);
    check(6'b000000, "R11 no destination");
    mode = M_RUN; run(2);
    check(6'b000000, "R11 persists in operational mode");
    mode = 3'b101; pres = 1; run(1);
    check(6'b010000, "R11 cleared, R1 reserved code as reset");
    mode = M_RUN; req = 0; run(1);

    // Constrained random traffic against the model
    void'($urandom(32'h1A2B_3C4D));
    len = 0;
    for (int i = 0; i < 6000; i++) begin
      if (len == 0) begin
        con = ($urandom % 2) == 1;
        len = 1 + ($urandom % 24);
      end
      len--;
      if ($urandom % 20 == 0) req = ~req;
      rdy  = ($urandom % 40) == 0;
      pres = ($urandom % 60) != 0;
      case ($urandom % 100)
        0: mode = M_RST;
        1: mode = M_WAIT;
        2: mode = 3'($urandom);
        default: mode = M_RUN;
      endcase
      tick();
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule